// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the bus-facing control core of a single-channel serial port. It decodes single-cycle reads and writes within a 64-byte register window. It holds two mode registers behind an auto-advancing pointer, and it keeps transmitter, receiver, error and interrupt state. It also interprets the packed command byte that resets or enables parts of the channel. The baud generator, the line shifters and the receive FIFO storage sit outside. The FIFO is seen only through its status inputs, its head byte, and two strobes: one to pop and one to flush.

A transmit byte written by software is offered to the serial shifter over a valid/ready pair. A single registered interrupt line is high when any enabled interrupt source is pending. A mode bit picks whether the receive interrupt means "data available" or "FIFO full".

Top module: `uart_regctl`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0x08, the interrupt status (offset 0x14) reads 0x00, both mode registers and the mask read 0x00, the pointer selects mode register 1, TX and RX are disabled and `irq` is low.
- R2: Any read or write at offset 0x00 accesses the mode register selected by the pointer, then moves the pointer to mode register 2. The pointer stays there until a command byte with bits [6:4] = 1 returns it to mode register 1.
- R3: In a command write (offset 0x08), bits [3:2] control TX and bits [1:0] control RX: 1 enables, 2 disables, 0 and 3 leave the state unchanged. `rxEnable` and status bit 2 (TX ready) show the enables from the next cycle.
- R4: A write to offset 0x0C stores the transmit byte and clears status bit 3 (TX empty). While TX is enabled and bit 3 is clear, `txValid` is high with the byte on `txData`. The cycle after a `txValid`/`txReady` handshake, bit 3 is set again.
- R5: Command bits [6:4] = 3 disables TX, sets status bit 3 and clears status bit 2. The TX field of the same byte is applied after that reset.
- R6: Command bits [6:4] = 2 pulses `rxFlush` in the write cycle, clears status bits 0 and 1 for the following cycle and disables RX. The RX field of the same byte is applied afterwards.
- R7: Status bit 0 (RX ready) and bit 1 (FIFO full) are registered copies of `rxNotEmpty` and `rxFull`, one cycle late.
- R8: A read at 0x0C returns `rxHead` and pulses `rxPop` in that cycle. A read at 0x04 returns status and a read at 0x14 returns interrupt status. Reads of 0x08, 0x10 and unmapped offsets return 0. A write at 0x14 loads the interrupt mask.
- R9: Interrupt status bit 0 equals status bit 2. Bit 1 equals status bit 1 when mode register 1 bit 6 is set, otherwise status bit 0. `irq` is high one cycle after (interrupt status AND mask) is nonzero.
- R10: `rxBreakEvt` sets interrupt status bit 2 and status bit 7 on the next cycle. Command bits [6:4] = 5 clears only interrupt status bit 2. A break arriving in the same cycle as the clear wins.
- R11: `rxOverrun`, `rxParityErr` and `rxFrameErr` set sticky status bits 4, 5 and 6. Command bits [6:4] = 4 clears bits 4 to 7, and a new error in the same cycle wins.
- R12: Writes to offsets 0x04 and 0x10, and command codes 6 and 7 in bits [6:4], change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 write, 0 read |
| busAddr | input | 6 | Byte offset in the register window |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the access cycle |
| rxNotEmpty | input | 1 | Receive FIFO holds at least one byte |
| rxFull | input | 1 | Receive FIFO is full |
| rxHead | input | 8 | Byte at the FIFO head |
| rxOverrun | input | 1 | Overrun error pulse |
| rxParityErr | input | 1 | Parity error pulse |
| rxFrameErr | input | 1 | Framing error pulse |
| rxBreakEvt | input | 1 | Received break pulse |
| rxPop | output | 1 | Pop FIFO head |
| rxFlush | output | 1 | Empty the FIFO |
| rxEnable | output | 1 | Receiver may accept bytes |
| txData | output | 8 | Byte offered to the shifter |
| txValid | output | 1 | Transmit byte offered |
| txReady | input | 1 | Shifter takes the byte |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench goes after command bytes that combine a reset code with an enable field. A design that applies the fields in the wrong order leaves the transmitter or receiver in the wrong state. The pointer is probed with a read-only access to offset 0x00: a pointer advanced only on writes would return mode register 1 twice. Break and error pulses are timed to land on the same edge as their clearing commands. A design where the clear wins loses an event that software never saw. The receive interrupt source is switched by mode register 1 bit 6 while the FIFO is partly full, which exposes a swapped select as a wrong `irq`.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;

  localparam int REG_W = 8;

  // status register bit positions
  localparam int SR_RXRDY = 0;
  localparam int SR_FFULL = 1;
  localparam int SR_TXRDY = 2;
  localparam int SR_TXEMP = 3;
  localparam int SR_ERR_LO = 4;

  // mode register 1 bit choosing the receive interrupt source
  localparam int MR1_RXSEL = 6;

  // miscellaneous command codes in command bits [6:4]
  localparam logic [2:0] MISC_PTR_RST = 3'd1;
  localparam logic [2:0] MISC_RX_RST  = 3'd2;
  localparam logic [2:0] MISC_TX_RST  = 3'd3;
  localparam logic [2:0] MISC_ERR_RST = 3'd4;
  localparam logic [2:0] MISC_DB_RST  = 3'd5;

  localparam logic [1:0] FLD_ENABLE  = 2'd1;
  localparam logic [1:0] FLD_DISABLE = 2'd2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MODE,
    RD_STAT,
    RD_RXD,
    RD_ISR
  } rdSelT;

  typedef struct packed {
    logic mrWr;
    logic mrAccess;
    logic imrWr;
    logic txbWr;
    logic ptrReset;
    logic rxReset;
    logic txReset;
    logic errReset;
    logic dbReset;
    logic txEnSet;
    logic txEnClr;
    logic rxEnSet;
    logic rxEnClr;
  } ctrlStrbT;

endpackage

// File: rtl/uart_regctl_ctrl.sv
module uart_regctl_ctrl
  import uart_regctl_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int OFS_MODE = 'h00,
  parameter int OFS_STAT = 'h04,
  parameter int OFS_CMD  = 'h08,
  parameter int OFS_DATA = 'h0C,
  parameter int OFS_IMR  = 'h14
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output ctrlStrbT          strb,
  output rdSelT             rdSel,
  output logic              rxPop,
  output logic              rxFlush
);

  localparam logic [ADDR_W-1:0] A_MODE = OFS_MODE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_STAT = OFS_STAT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CMD  = OFS_CMD[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_DATA = OFS_DATA[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_IMR  = OFS_IMR[ADDR_W-1:0];

  logic wrEn, rdEn;
  logic hitMode, hitStat, hitCmd, hitData, hitImr;
  logic cmdWr;
  logic [2:0] miscCode;
  logic [1:0] txFld, rxFld;

  assign wrEn = busSel & busWr;
  assign rdEn = busSel & ~busWr;

  assign hitMode = (busAddr == A_MODE);
  assign hitStat = (busAddr == A_STAT);
  assign hitCmd  = (busAddr == A_CMD);
  assign hitData = (busAddr == A_DATA);
  assign hitImr  = (busAddr == A_IMR);

  assign cmdWr    = wrEn & hitCmd;
  assign miscCode = busWdata[6:4];
  assign txFld    = busWdata[3:2];
  assign rxFld    = busWdata[1:0];

  always_comb begin
    strb          = '0;
    strb.mrWr     = wrEn & hitMode;
    strb.mrAccess = busSel & hitMode;
    strb.imrWr    = wrEn & hitImr;
    strb.txbWr    = wrEn & hitData;
    strb.ptrReset = cmdWr && (miscCode == MISC_PTR_RST);
    strb.rxReset  = cmdWr && (miscCode == MISC_RX_RST);
    strb.txReset  = cmdWr && (miscCode == MISC_TX_RST);
    strb.errReset = cmdWr && (miscCode == MISC_ERR_RST);
    strb.dbReset  = cmdWr && (miscCode == MISC_DB_RST);
    strb.txEnSet  = cmdWr && (txFld == FLD_ENABLE);
    strb.txEnClr  = cmdWr && (txFld == FLD_DISABLE);
    strb.rxEnSet  = cmdWr && (rxFld == FLD_ENABLE);
    strb.rxEnClr  = cmdWr && (rxFld == FLD_DISABLE);
  end

  always_comb begin
    rdSel = RD_NONE;
    if (rdEn) begin
      if (hitMode)      rdSel = RD_MODE;
      else if (hitStat) rdSel = RD_STAT;
      else if (hitData) rdSel = RD_RXD;
      else if (hitImr)  rdSel = RD_ISR;
    end
  end

  assign rxPop   = rdEn & hitData;
  assign rxFlush = strb.rxReset;

endmodule

// File: rtl/uart_regctl_dp.sv
module uart_regctl_dp
  import uart_regctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrbT         strb,
  input  rdSelT            rdSel,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic             rxNotEmpty,
  input  logic             rxFull,
  input  logic [REG_W-1:0] rxHead,
  input  logic             rxOverrun,
  input  logic             rxParityErr,
  input  logic             rxFrameErr,
  input  logic             rxBreakEvt,
  output logic             rxEnable,
  output logic [REG_W-1:0] txData,
  output logic             txValid,
  input  logic             txReady,
  output logic             irq
);

  localparam int N_ERR = 3;

  logic [REG_W-1:0] mr1, mr2, imr, txBuf;
  logic ptrMr2;
  logic txEn, txEmp, rxEn;
  logic rxRdy, fFull;
  logic errBrk, dbInt, irqQ;
  logic [N_ERR-1:0] errIn, errSticky;
  logic [REG_W-1:0] srVal, isrVal;
  logic txInt, rxInt;

  // mode registers and pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mr1    <= '0;
      mr2    <= '0;
      ptrMr2 <= 1'b0;
    end else begin
      if (strb.mrWr) begin
        if (ptrMr2) mr2 <= busWdata;
        else        mr1 <= busWdata;
      end
      if (strb.mrAccess) ptrMr2 <= 1'b1;
      if (strb.ptrReset) ptrMr2 <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) imr <= '0;
    else if (strb.imrWr) imr <= busWdata;
  end

  // transmit path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf <= '0;
      txEmp <= 1'b1;
      txEn  <= 1'b0;
    end else begin
      if (txValid && txReady) txEmp <= 1'b1;
      if (strb.txbWr) begin
        txBuf <= busWdata;
        txEmp <= 1'b0;
      end
      if (strb.txReset) begin
        txEmp <= 1'b1;
        txEn  <= 1'b0;
      end
      if (strb.txEnSet)      txEn <= 1'b1;
      else if (strb.txEnClr) txEn <= 1'b0;
    end
  end

  assign txValid = txEn & ~txEmp;
  assign txData  = txBuf;

  // receive status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEn  <= 1'b0;
      rxRdy <= 1'b0;
      fFull <= 1'b0;
    end else begin
      rxRdy <= rxNotEmpty & ~strb.rxReset;
      fFull <= rxFull & ~strb.rxReset;
      if (strb.rxReset)      rxEn <= 1'b0;
      if (strb.rxEnSet)      rxEn <= 1'b1;
      else if (strb.rxEnClr) rxEn <= 1'b0;
    end
  end

  assign rxEnable = rxEn;

  // sticky line errors, one flop per source
  assign errIn = {rxFrameErr, rxParityErr, rxOverrun};

  for (genvar g = 0; g < N_ERR; g++) begin : gErr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) errSticky[g] <= 1'b0;
      else if (errIn[g]) errSticky[g] <= 1'b1;
      else if (strb.errReset) errSticky[g] <= 1'b0;
    end
  end

  // received break: status bit and delta interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errBrk <= 1'b0;
      dbInt  <= 1'b0;
    end else begin
      if (rxBreakEvt)         errBrk <= 1'b1;
      else if (strb.errReset) errBrk <= 1'b0;
      if (rxBreakEvt)         dbInt <= 1'b1;
      else if (strb.dbReset)  dbInt <= 1'b0;
    end
  end

  // status and interrupt status
  assign srVal = {errBrk, errSticky, txEmp, txEn, fFull, rxRdy};
  assign txInt = srVal[SR_TXRDY];
  assign rxInt = mr1[MR1_RXSEL] ? srVal[SR_FFULL] : srVal[SR_RXRDY];
  assign isrVal = {1'b0, 4'b0000, dbInt, rxInt, txInt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(isrVal & imr);
  end

  assign irq = irqQ;

  always_comb begin
    case (rdSel)
      RD_MODE: busRdata = ptrMr2 ? mr2 : mr1;
      RD_STAT: busRdata = srVal;
      RD_RXD:  busRdata = rxHead;
      RD_ISR:  busRdata = isrVal;
      default: busRdata = '0;
    endcase
  end

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.mrAccess |=> ptrMr2); // R2

  AST_TX_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && !strb.txbWr) |=> !txValid); // R4

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !strb.txbWr && !strb.txReset && !strb.txEnClr)
      |=> (txValid && $stable(txData))); // R4

  AST_TX_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txReset && !strb.txEnSet) |=> (!txValid && srVal[SR_TXEMP] && !srVal[SR_TXRDY])); // R5

  AST_RX_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxReset && !strb.rxEnSet) |=> (!rxEnable && !srVal[SR_RXRDY] && !srVal[SR_FFULL])); // R6

  AST_BREAK_SET: assert property (@(posedge clk) disable iff (!rstN)
    rxBreakEvt |=> (isrVal[2] && srVal[7])); // R10

endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
  import uart_regctl_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int OFS_MODE = 'h00,
  parameter int OFS_STAT = 'h04,
  parameter int OFS_CMD  = 'h08,
  parameter int OFS_DATA = 'h0C,
  parameter int OFS_IMR  = 'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              rxNotEmpty,
  input  logic              rxFull,
  input  logic [7:0]        rxHead,
  input  logic              rxOverrun,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic              rxBreakEvt,
  output logic              rxPop,
  output logic              rxFlush,
  output logic              rxEnable,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              irq
);

  ctrlStrbT strb;
  rdSelT    rdSel;

  uart_regctl_ctrl #(
    .ADDR_W(ADDR_W), .OFS_MODE(OFS_MODE), .OFS_STAT(OFS_STAT),
    .OFS_CMD(OFS_CMD), .OFS_DATA(OFS_DATA), .OFS_IMR(OFS_IMR)
  ) uCtrl (
    .busSel(busSel),
    .busWr(busWr),
    .busAddr(busAddr),
    .busWdata(busWdata),
    .strb(strb),
    .rdSel(rdSel),
    .rxPop(rxPop),
    .rxFlush(rxFlush)
  );

  uart_regctl_dp uDp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .rdSel(rdSel),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .rxNotEmpty(rxNotEmpty),
    .rxFull(rxFull),
    .rxHead(rxHead),
    .rxOverrun(rxOverrun),
    .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr),
    .rxBreakEvt(rxBreakEvt),
    .rxEnable(rxEnable),
    .txData(txData),
    .txValid(txValid),
    .txReady(txReady),
    .irq(irq)
  );

endmodule

// File: tb/uart_regctl_test.sv
module uart_regctl_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic rxNotEmpty = 1'b0, rxFull = 1'b0;
  logic [7:0] rxHead = '0;
  logic rxOverrun = 1'b0, rxParityErr = 1'b0, rxFrameErr = 1'b0, rxBreakEvt = 1'b0;
  logic rxPop, rxFlush, rxEnable, txValid, irq;
  logic [7:0] txData;
  logic txReady = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string curTag = "";
  int unsigned seed = 32'h1234_5678;

  // reference model state
  logic [7:0] mMr1, mMr2, mImr, mTxBuf;
  bit mPtr, mTxEmp, mTxEn, mRxEn, mRxRdy, mFFull;
  bit mOe, mPe, mFe, mBrk, mDb, mIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regctl uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxNotEmpty(rxNotEmpty),
    .rxFull(rxFull), .rxHead(rxHead), .rxOverrun(rxOverrun),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr), .rxBreakEvt(rxBreakEvt),
    .rxPop(rxPop), .rxFlush(rxFlush), .rxEnable(rxEnable), .txData(txData),
    .txValid(txValid), .txReady(txReady), .irq(irq)
  );

  function automatic logic [7:0] mSr();
    return {mBrk, mFe, mPe, mOe, mTxEmp, mTxEn, mFFull, mRxRdy};
  endfunction

  function automatic logic [7:0] mIsr();
    bit rxi;
    rxi = mMr1[6] ? mFFull : mRxRdy;
    return {5'b00000, mDb, rxi, mTxEn};
  endfunction

  function automatic logic [7:0] expRd();
    if (!busSel || busWr) return 8'h00;
    case (busAddr)
      6'h00: return mPtr ? mMr2 : mMr1;
      6'h04: return mSr();
      6'h0C: return rxHead;
      6'h14: return mIsr();
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelReset();
    mMr1 = 0; mMr2 = 0; mImr = 0; mTxBuf = 0;
    mPtr = 0; mTxEmp = 1; mTxEn = 0; mRxEn = 0; mRxRdy = 0; mFFull = 0;
    mOe = 0; mPe = 0; mFe = 0; mBrk = 0; mDb = 0; mIrq = 0;
  endtask

  task automatic modelStep();
    bit wr, cmd;
    bit [2:0] misc;
    bit [1:0] tf, rf;
    bit nIrq;
    if (!rstN) begin
      modelReset();
      return;
    end
    wr   = busSel && busWr;
    cmd  = wr && busAddr == 6'h08;
    misc = cmd ? busWdata[6:4] : 3'd0;
    tf   = cmd ? busWdata[3:2] : 2'd0;
    rf   = cmd ? busWdata[1:0] : 2'd0;
    nIrq = |(mIsr() & mImr);
    if (busSel && busAddr == 6'h00) begin
      if (wr) begin
        if (mPtr) mMr2 = busWdata; else mMr1 = busWdata;
      end
      mPtr = 1;
    end
    if (misc == 1) mPtr = 0;
    if (wr && busAddr == 6'h14) mImr = busWdata;
    if (mTxEn && !mTxEmp && txReady) mTxEmp = 1;
    if (wr && busAddr == 6'h0C) begin mTxBuf = busWdata; mTxEmp = 0; end
    if (misc == 3) begin mTxEmp = 1; mTxEn = 0; end
    if (tf == 1) mTxEn = 1; else if (tf == 2) mTxEn = 0;
    mRxRdy = (misc == 2) ? 1'b0 : rxNotEmpty;
    mFFull = (misc == 2) ? 1'b0 : rxFull;
    if (misc == 2) mRxEn = 0;
    if (rf == 1) mRxEn = 1; else if (rf == 2) mRxEn = 0;
    if (misc == 4) begin mOe = 0; mPe = 0; mFe = 0; mBrk = 0; end
    if (rxOverrun) mOe = 1;
    if (rxParityErr) mPe = 1;
    if (rxFrameErr) mFe = 1;
    if (rxBreakEvt) mBrk = 1;
    if (misc == 5) mDb = 0;
    if (rxBreakEvt) mDb = 1;
    mIrq = nIrq;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%02h expected=%02h", tag, $time, act, exp);
    end
  endtask

  task automatic stepCycle();
    bit expFlush, expPop;
    #1;
    expFlush = busSel && busWr && busAddr == 6'h08 && busWdata[6:4] == 3'd2;
    expPop   = busSel && !busWr && busAddr == 6'h0C;
    chk((curTag == "") ? "R8" : curTag, busRdata, expRd());
    chk("R4", {7'd0, txValid}, {7'd0, mTxEn && !mTxEmp});
    if (mTxEn && !mTxEmp) chk("R4", txData, mTxBuf);
    chk("R9", {7'd0, irq}, {7'd0, mIrq});
    chk("R3", {7'd0, rxEnable}, {7'd0, mRxEn});
    chk("R6", {7'd0, rxFlush}, {7'd0, expFlush});
    chk("R8", {7'd0, rxPop}, {7'd0, expPop});
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) stepCycle();
  endtask

  task automatic wrReg(logic [5:0] a, logic [7:0] d);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    stepCycle();
    busSel = 0; busWr = 0;
  endtask

  task automatic rdReg(logic [5:0] a, string tag);
    busSel = 1; busWr = 0; busAddr = a; curTag = tag;
    stepCycle();
    busSel = 0; curTag = "";
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  initial begin
    modelReset();
    @(negedge clk);
    @(negedge clk);
    // R1: reset values visible while reset is held
    rdReg(6'h04, "R1");
    rdReg(6'h14, "R1");
    rdReg(6'h00, "R1");
    rstN = 1;
    idle(2);
    rdReg(6'h04, "R1");

    // R2: pointer advance on read and write, reset by misc code 1
    wrReg(6'h08, 8'h10);
    rdReg(6'h00, "R2");
    rdReg(6'h00, "R2");
    wrReg(6'h00, 8'h5A);
    wrReg(6'h08, 8'h10);
    wrReg(6'h00, 8'h21);
    wrReg(6'h00, 8'h7E);
    rdReg(6'h00, "R2");
    wrReg(6'h08, 8'h10);
    rdReg(6'h00, "R2");

    // R12: ignored offsets and break commands
    wrReg(6'h04, 8'hFF);
    wrReg(6'h10, 8'hFF);
    wrReg(6'h08, 8'h60);
    wrReg(6'h08, 8'h70);
    rdReg(6'h04, "R12");
    rdReg(6'h14, "R12");
    rdReg(6'h00, "R12");
    rdReg(6'h08, "R8");
    rdReg(6'h10, "R8");
    rdReg(6'h38, "R8");

    // R3: enables, reserved field values
    wrReg(6'h08, 8'h05);
    rdReg(6'h04, "R3");
    wrReg(6'h08, 8'h0F);
    rdReg(6'h04, "R3");
    wrReg(6'h08, 8'h0A);
    rdReg(6'h04, "R3");
    wrReg(6'h08, 8'h05);

    // R4 / R9: transmit handshake and TX interrupt
    wrReg(6'h14, 8'h01);
    idle(2);
    wrReg(6'h0C, 8'hA5);
    idle(3);
    rdReg(6'h04, "R4");
    txReady = 1;
    idle(1);
    txReady = 0;
    rdReg(6'h04, "R4");
    wrReg(6'h0C, 8'h3C);
    txReady = 1;
    wrReg(6'h0C, 8'hC3);
    idle(2);
    txReady = 0;

    // R5: transmitter reset alone and with a re-enable field
    wrReg(6'h0C, 8'h11);
    wrReg(6'h08, 8'h30);
    rdReg(6'h04, "R5");
    wrReg(6'h0C, 8'h22);
    wrReg(6'h08, 8'h34);
    rdReg(6'h04, "R5");
    txReady = 1;
    idle(1);
    txReady = 0;

    // R7 / R8 / R9: receive status, pop, interrupt source select
    wrReg(6'h14, 8'h02);
    rxNotEmpty = 1; rxHead = 8'h6B;
    idle(1);
    rdReg(6'h04, "R7");
    rdReg(6'h0C, "R8");
    rdReg(6'h14, "R9");
    wrReg(6'h08, 8'h10);
    wrReg(6'h00, 8'h40);
    idle(2);
    rdReg(6'h14, "R9");
    rxFull = 1;
    idle(2);
    rdReg(6'h04, "R7");
    rdReg(6'h14, "R9");

    // R6: receiver reset, alone and with re-enable
    wrReg(6'h08, 8'h20);
    rdReg(6'h04, "R6");
    wrReg(6'h08, 8'h21);
    rxNotEmpty = 0; rxFull = 0;
    idle(1);
    rdReg(6'h04, "R6");

    // R10 / R11: break and errors, clears with same-cycle collisions
    wrReg(6'h14, 8'h04);
    rxBreakEvt = 1; idle(1); rxBreakEvt = 0;
    rdReg(6'h14, "R10");
    rdReg(6'h04, "R10");
    wrReg(6'h08, 8'h50);
    rdReg(6'h14, "R10");
    rdReg(6'h04, "R10");
    rxBreakEvt = 1; wrReg(6'h08, 8'h50); rxBreakEvt = 0;
    rdReg(6'h14, "R10");
    rxOverrun = 1; rxFrameErr = 1; idle(1); rxOverrun = 0; rxFrameErr = 0;
    rdReg(6'h04, "R11");
    rxParityErr = 1; idle(1); rxParityErr = 0;
    rdReg(6'h04, "R11");
    wrReg(6'h08, 8'h40);
    rdReg(6'h04, "R11");
    rxParityErr = 1; wrReg(6'h08, 8'h40); rxParityErr = 0;
    rdReg(6'h04, "R11");

    // mixed pseudo-random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic [5:0] addrs [7];
      addrs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18};
      r = rnd();
      busSel = r[0];
      busWr = r[1];
      busAddr = addrs[r[10:8] % 7];
      busWdata = r[23:16];
      txReady = r[2];
      rxNotEmpty = r[3] | r[4];
      rxFull = r[3] & r[4];
      rxHead = r[31:24];
      r = rnd();
      rxOverrun = (r[4:0] == 0);
      rxParityErr = (r[9:5] == 0);
      rxFrameErr = (r[14:10] == 0);
      rxBreakEvt = (r[19:15] == 0);
      stepCycle();
    end
    busSel = 0; rxOverrun = 0; rxParityErr = 0; rxFrameErr = 0; rxBreakEvt = 0;
    idle(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule